// File: doc/BRIEF.md
# Four-Channel Asynchronous Strobe FIFO Slave

This block sits on the peripheral side of a byte-wide parallel bus and holds four independent byte FIFOs. A 2-bit channel select on the bus picks the FIFO for each access. The bus master reads and writes bytes with active-low strobes that need no relation to the slave clock. The strobes are brought into the slave clock through two flip-flops, and each byte is taken on the release edge of its strobe.

Bytes the master writes collect in an open packet that the local side cannot see. The packet becomes visible when it reaches the maximum packet size, or when the master pulses the packet-end strobe. Bytes that the local side pushes can be read by the master at once. Two flag pins show the state of one fixed channel each: one flag shows the emptiness of the channel the master reads from, and the other shows the fullness of the channel the master writes to. A write to a full channel and a read from an empty channel are dropped and recorded in sticky error bits.

Top module: `afifo_slave4`

## Requirements
- R1: `bus_sel` chooses the channel (0 to 3) for every strobe access. An access to one channel leaves the contents and commit state of every other channel unchanged.
- R2: A write strobe stores `bus_in` into the selected channel when `wr_n` rises. The byte stays invisible to the local pop side (`lcl_avail` low) until its packet is committed.
- R3: When the open packet of a channel reaches PKT_MAX bytes, it commits automatically.
- R4: A rising edge of `pktend_n` commits the open packet of the selected channel. With zero open bytes it has no effect.
- R5: While `rd_n` is low, `bus_out` shows the oldest committed byte of the selected channel. The byte is removed when `rd_n` rises. `bus_oe` equals the inverse of `oe_n`.
- R6: A local push (`lcl_push` high for one cycle) appends `lcl_wdata` to channel `lcl_push_ch` and commits it together with any open bytes. A local pop takes committed bytes in write order, and `lcl_rdata` shows the head of `lcl_pop_ch`.
- R7: `flag_empty` is high when channel RD_CH holds no committed byte. `flag_full` is high when channel WR_CH has no room for one more byte. Both flags settle within 3 clock cycles after a strobe rises.
- R8: A write strobe to a full channel is dropped and sets `err_ovf`, which stays set until reset.
- R9: A read strobe on a channel with no committed byte is dropped and sets `err_udf`, which stays set until reset.
- R10: After reset all channels are empty, `flag_empty` is 1, `flag_full` is 0, both error bits are 0 and `lcl_avail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Channel select for strobe accesses |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable for the data bus, active low |
| pktend_n | input | 1 | Packet-end strobe, active low |
| bus_in | input | 8 | Write data from the master |
| bus_out | output | 8 | Read data to the master |
| bus_oe | output | 1 | High when the slave drives the bus |
| flag_empty | output | 1 | Channel RD_CH holds no committed byte |
| flag_full | output | 1 | Channel WR_CH has no free byte |
| err_ovf | output | 1 | Sticky: a write hit a full channel |
| err_udf | output | 1 | Sticky: a read hit an empty channel |
| lcl_push | input | 1 | Local push request |
| lcl_push_ch | input | 2 | Channel for the local push |
| lcl_wdata | input | 8 | Local push data |
| lcl_pop | input | 1 | Local pop request |
| lcl_pop_ch | input | 2 | Channel for the local pop and head view |
| lcl_rdata | output | 8 | Head byte of channel `lcl_pop_ch` |
| lcl_avail | output | 1 | Channel `lcl_pop_ch` holds a committed byte |

## Verification
The bench builds the block with PKT_MAX=4 and DEPTH=8, with RD_CH=1 and WR_CH=2. With these values an automatic commit, the point where a channel holds exactly two packets, a full flag and an overflow write all take only a few strobes, and the write and read pointers wrap inside the run. With the default 512-byte packets these cases would need thousands of strobes to reach.

// File: rtl/afifo_slave4.sv
module afifo_slave4 #(
  parameter int PKT_MAX = 512,
  parameter int DEPTH   = 1024,
  parameter int RD_CH   = 0,
  parameter int WR_CH   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       oe_n,
  input  logic       pktend_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic       flag_empty,
  output logic       flag_full,
  output logic       err_ovf,
  output logic       err_udf,
  input  logic       lcl_push,
  input  logic [1:0] lcl_push_ch,
  input  logic [7:0] lcl_wdata,
  input  logic       lcl_pop,
  input  logic [1:0] lcl_pop_ch,
  output logic [7:0] lcl_rdata,
  output logic       lcl_avail
);
  localparam int NCH = 4;
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] PKT_P   = PW'(PKT_MAX);

  // strobe synchronizers: [0],[1] sync stages, [2] history for edge detect
  logic [2:0] rd_s, wr_s, pe_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_s <= 3'b111;
      wr_s <= 3'b111;
      pe_s <= 3'b111;
    end else begin
      rd_s <= {rd_s[1:0], rd_n};
      wr_s <= {wr_s[1:0], wr_n};
      pe_s <= {pe_s[1:0], pktend_n};
    end

  wire rd_ev = rd_s[1] & ~rd_s[2];
  wire wr_ev = wr_s[1] & ~wr_s[2];
  wire pe_ev = pe_s[1] & ~pe_s[2];

  logic [PW-1:0] wp [NCH];
  logic [PW-1:0] cp [NCH];
  logic [PW-1:0] rp [NCH];
  logic [PW-1:0] used [NCH];
  logic [PW-1:0] open_n [NCH];
  logic [PW-1:0] cmt_n [NCH];
  logic [7:0]    head [NCH];
  logic [NCH-1:0] ovf_hit, udf_hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] mem [DEPTH];
    wire sel_me  = (bus_sel == 2'(c));
    wire is_full = (used[c] == DEPTH_P);
    wire s_wr    = wr_ev & sel_me;
    wire l_wr    = lcl_push & (lcl_push_ch == 2'(c)) & ~s_wr;
    wire do_wr   = (s_wr | l_wr) & ~is_full;
    wire s_rd    = rd_ev & sel_me;
    wire l_rd    = lcl_pop & (lcl_pop_ch == 2'(c)) & ~s_rd;
    wire do_rd   = (s_rd | l_rd) & (cmt_n[c] != '0);
    wire do_pe   = pe_ev & sel_me & (open_n[c] != '0);

    assign used[c]   = wp[c] - rp[c];
    assign open_n[c] = wp[c] - cp[c];
    assign cmt_n[c]  = cp[c] - rp[c];
    assign head[c]   = mem[rp[c][AW-1:0]];
    assign ovf_hit[c] = s_wr & is_full;
    assign udf_hit[c] = s_rd & (cmt_n[c] == '0);

    always_ff @(posedge clk)
      if (do_wr) mem[wp[c][AW-1:0]] <= s_wr ? bus_in : lcl_wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp[c] <= '0;
        cp[c] <= '0;
        rp[c] <= '0;
      end else begin
        if (do_wr) begin
          wp[c] <= wp[c] + 1'b1;
          if (l_wr || (open_n[c] + 1'b1 == PKT_P)) cp[c] <= wp[c] + 1'b1;
        end else if (do_pe) begin
          cp[c] <= wp[c];
        end
        if (do_rd) rp[c] <= rp[c] + 1'b1;
      end

    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr && is_full) |=> $stable(wp[c])); // R8
    AST_UDF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rd && cmt_n[c] == '0) |=> $stable(rp[c])); // R9
    AST_PE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_ev && sel_me && open_n[c] == '0 && !(lcl_push && lcl_push_ch == 2'(c))) |=> $stable(cp[c])); // R4
    AST_OPEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      open_n[c] < PKT_P); // R3
    AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      used[c] <= DEPTH_P); // R8
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_ovf <= 1'b0;
      err_udf <= 1'b0;
    end else begin
      err_ovf <= err_ovf | (|ovf_hit);
      err_udf <= err_udf | (|udf_hit);
    end

  assign bus_out    = head[bus_sel];
  assign bus_oe     = ~oe_n;
  assign flag_empty = (cmt_n[RD_CH] == '0);
  assign flag_full  = (used[WR_CH] == DEPTH_P);
  assign lcl_rdata  = head[lcl_pop_ch];
  assign lcl_avail  = (cmt_n[lcl_pop_ch] != '0);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf); // R8
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_udf |=> err_udf); // R9
  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe != oe_n); // R5
endmodule

// File: tb/sim_afifo_slave4.sv
module sim_afifo_slave4;
  localparam int OP_WR = 0, OP_RD = 1, OP_PE = 2, OP_PU = 3, OP_PO = 4;
  localparam int OP_AV = 5, OP_FE = 6, OP_FF = 7, OP_EO = 8, OP_EU = 9, OP_RX = 10;
  localparam int NV = 54;
  // {op, channel, data or expected}
  localparam logic [13:0] VEC [NV] = '{
    {4'd5,2'd2,8'h00}, {4'd0,2'd2,8'hA1}, {4'd5,2'd2,8'h00}, {4'd0,2'd2,8'hA2},
    {4'd0,2'd2,8'hA3}, {4'd5,2'd2,8'h00}, {4'd0,2'd2,8'hA4}, {4'd5,2'd2,8'h01},
    {4'd4,2'd2,8'hA1}, {4'd4,2'd2,8'hA2}, {4'd4,2'd2,8'hA3}, {4'd4,2'd2,8'hA4},
    {4'd5,2'd2,8'h00}, {4'd0,2'd3,8'h55}, {4'd5,2'd2,8'h00}, {4'd2,2'd3,8'h00},
    {4'd5,2'd3,8'h01}, {4'd4,2'd3,8'h55}, {4'd2,2'd3,8'h00}, {4'd5,2'd3,8'h00},
    {4'd8,2'd0,8'h00}, {4'd6,2'd0,8'h01}, {4'd3,2'd1,8'h10}, {4'd3,2'd1,8'h11},
    {4'd6,2'd0,8'h00}, {4'd1,2'd1,8'h10}, {4'd1,2'd1,8'h11}, {4'd6,2'd0,8'h01},
    {4'd10,2'd1,8'h00},{4'd9,2'd0,8'h01}, {4'd6,2'd0,8'h01}, {4'd0,2'd2,8'hB0},
    {4'd0,2'd2,8'hB1}, {4'd0,2'd2,8'hB2}, {4'd0,2'd2,8'hB3}, {4'd0,2'd2,8'hB4},
    {4'd0,2'd2,8'hB5}, {4'd0,2'd2,8'hB6}, {4'd7,2'd0,8'h00}, {4'd0,2'd2,8'hB7},
    {4'd7,2'd0,8'h01}, {4'd0,2'd2,8'hC0}, {4'd8,2'd0,8'h01}, {4'd7,2'd0,8'h01},
    {4'd4,2'd2,8'hB0}, {4'd7,2'd0,8'h00}, {4'd4,2'd2,8'hB1}, {4'd4,2'd2,8'hB2},
    {4'd4,2'd2,8'hB3}, {4'd4,2'd2,8'hB4}, {4'd4,2'd2,8'hB5}, {4'd4,2'd2,8'hB6},
    {4'd4,2'd2,8'hB7}, {4'd5,2'd2,8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_sel = 0, lcl_push_ch = 0, lcl_pop_ch = 0;
  logic rd_n = 1, wr_n = 1, oe_n = 1, pktend_n = 1, lcl_push = 0, lcl_pop = 0;
  logic [7:0] bus_in = 0, lcl_wdata = 0;
  logic [7:0] bus_out, lcl_rdata;
  logic bus_oe, flag_empty, flag_full, err_ovf, err_udf, lcl_avail;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  afifo_slave4 #(.PKT_MAX(4), .DEPTH(8), .RD_CH(1), .WR_CH(2)) u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_wr(input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk); bus_sel = ch; bus_in = d; wr_n = 0;
    wait_n(3); wr_n = 1; wait_n(5);
  endtask

  task automatic strobe_pe(input logic [1:0] ch);
    @(negedge clk); bus_sel = ch; pktend_n = 0;
    wait_n(3); pktend_n = 1; wait_n(5);
  endtask

  task automatic strobe_rd(input logic [1:0] ch, input bit chk, input logic [7:0] exp);
    @(negedge clk); bus_sel = ch; rd_n = 0; oe_n = 0;
    wait_n(3);
    if (chk) begin
      check("R5 read data", bus_out, exp);
      check("R5 bus_oe on", {7'd0, bus_oe}, 8'd1);
    end
    rd_n = 1; oe_n = 1; wait_n(5);
  endtask

  task automatic local_push(input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk); lcl_push_ch = ch; lcl_wdata = d; lcl_push = 1;
    @(negedge clk); lcl_push = 0; wait_n(1);
  endtask

  task automatic local_pop(input logic [1:0] ch, input logic [7:0] exp);
    @(negedge clk); lcl_pop_ch = ch;
    #1 check("R6 local pop data", lcl_rdata, exp);
    check("R6 pop avail", {7'd0, lcl_avail}, 8'd1);
    @(negedge clk); lcl_pop = 1;
    @(negedge clk); lcl_pop = 0; wait_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    // R10 reset state
    check("R10 flag_empty", {7'd0, flag_empty}, 8'd1);
    check("R10 flag_full", {7'd0, flag_full}, 8'd0);
    check("R10 err_ovf", {7'd0, err_ovf}, 8'd0);
    check("R10 err_udf", {7'd0, err_udf}, 8'd0);
    rst_n = 1;
    wait_n(2);
    check("R10 lcl_avail", {7'd0, lcl_avail}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      automatic int op = int'(VEC[i][13:10]);
      automatic logic [1:0] ch = VEC[i][9:8];
      automatic logic [7:0] d = VEC[i][7:0];
      case (op)
        OP_WR: strobe_wr(ch, d);
        OP_RD: strobe_rd(ch, 1'b1, d);
        OP_RX: strobe_rd(ch, 1'b0, 8'h00);
        OP_PE: strobe_pe(ch);
        OP_PU: local_push(ch, d);
        OP_PO: local_pop(ch, d);
        OP_AV: begin
          @(negedge clk); lcl_pop_ch = ch;
          #1 check("R1 R2 R3 R4 avail", {7'd0, lcl_avail}, d);
        end
        OP_FE: check("R7 flag_empty", {7'd0, flag_empty}, d);
        OP_FF: check("R7 flag_full", {7'd0, flag_full}, d);
        OP_EO: check("R8 err_ovf", {7'd0, err_ovf}, d);
        OP_EU: check("R9 err_udf", {7'd0, err_udf}, d);
        default: ;
      endcase
    end

    // R5 bus_oe follows the output enable alone
    @(negedge clk); oe_n = 0; #1 check("R5 oe low", {7'd0, bus_oe}, 8'd1);
    @(negedge clk); oe_n = 1; #1 check("R5 oe high", {7'd0, bus_oe}, 8'd0);

    // R7 flag settles within 3 cycles after the strobe rises
    local_push(2'd1, 8'h7E);
    check("R7 flag_empty after push", {7'd0, flag_empty}, 8'd0);
    @(negedge clk); bus_sel = 2'd1; rd_n = 0; oe_n = 0;
    wait_n(3); rd_n = 1; oe_n = 1;
    wait_n(3);
    check("R7 flag_empty within bound", {7'd0, flag_empty}, 8'd1);

    // R10 reset clears data and sticky errors
    local_push(2'd1, 8'h3C);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R10 empty after reset", {7'd0, flag_empty}, 8'd1);
    check("R10 ovf cleared", {7'd0, err_ovf}, 8'd0);
    check("R10 udf cleared", {7'd0, err_udf}, 8'd0);
    rst_n = 1;
    wait_n(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule